// File: doc/BRIEF.md
# Dual-Port Double-Data-Rate Burst-of-Two SRAM Core

This block is a synchronous static memory with one port that only reads and one that only writes. Both ports can work in the same clock cycle. Two complementary input clocks pace the block. K is the main clock and K_n is its inverse. Commands and the read address are taken on K rising edges. The write address is taken on the K_n rising edge in the same cycle. Every access moves exactly two words, one on each half of a clock period.

The array holds word pairs. A pair address selects an even word, which is beat 0, and an odd word, which is beat 1. Write data comes in before its address is known, so beat 0 waits in a one-entry buffer. The whole pair is written once the address has been captured. Each byte lane of each beat has its own active-low enable.

Read data leaves through a fixed two-cycle pipeline. A data-valid flag marks the two half-cycles that carry the burst. A write issued on the same K edge as a read, or earlier, is always visible to that read. A synchronous reset empties the pipelines but keeps the array contents.

Top module: `qdrb2_sram`

## Requirements
- R1: Each accepted read produces exactly two valid beats, one full K period in total. No third beat follows unless another read was accepted.
- R2: `rd_n` and `rd_addr` are sampled only on the rising edge of `k_clk`. Their values at `kn_clk` edges have no effect.
- R3: For a write accepted on a K rising edge (`wr_n` low), beat-0 data on `d` and beat-0 masks on `bw_n` are taken at that same edge. `wr_addr`, beat-1 data and beat-1 masks are taken at the next `kn_clk` rising edge.
- R4: `bw_n[i]` selects byte lane i, which is bits `[i*LANE_W +: LANE_W]` of the word. The lane is written when the bit is 0 and left unchanged when it is 1. The masks of the two beats are independent.
- R5: For a read accepted at K edge n, `q` carries the even word of the pair from the `kn_clk` rising edge at n+1.5 cycles until K edge n+2. It carries the odd word from K edge n+2 until the `kn_clk` edge at n+2.5.
- R6: `q_valid` is 1 exactly during the two half-cycles of R5. At every other time `q_valid` is 0 and `q` is all zeros.
- R7: A read returns the data of every write accepted on the same K edge or an earlier one, with masked bytes merged. A write accepted on a later K edge does not change that read's result.
- R8: When `rd_n` and `wr_n` are both low on the same K edge, the read and the write are both performed.
- R9: Reads accepted on consecutive K edges give an unbroken run of valid beats, with `q_valid` high throughout.
- R10: While `rst` is high on a clock edge, that edge clears the read pipeline and the pending write buffer, and `q_valid` drops to 0. A write command sampled while `rst` is high is discarded, and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k_clk | input | 1 | Main clock; command and read-address capture |
| kn_clk | input | 1 | Inverse clock; write-address and beat-1 capture |
| rst | input | 1 | Synchronous reset, active high |
| rd_n | input | 1 | Read request, active low |
| rd_addr | input | PAIR_AW | Read pair address |
| wr_n | input | 1 | Write request, active low |
| wr_addr | input | PAIR_AW | Write pair address |
| d | input | DATA_W | Write data, beat 0 at K and beat 1 at K_n |
| bw_n | input | DATA_W/LANE_W | Per-lane write masks, active low |
| q | output | DATA_W | Read data, zero when not valid |
| q_valid | output | 1 | High while `q` carries a read beat |

## Verification
The assertions assume that `kn_clk` is the exact inverse of `k_clk`. They also assume that `rd_addr` is defined whenever a read is requested, and that `d`, `bw_n` and `wr_addr` are defined at every edge where a write takes them. The stimulus changes inputs only 2 ns after an edge, so every value is stable at the edge that samples it. Undriven fields are tied to zero or to all-ones masks. Every pair the bench reads has been written at full width first, so no read ever returns uninitialised array contents.

// File: rtl/qdrb2_pkg.sv
package qdrb2_pkg;
    // Fixed transfer length: every access moves an even/odd word pair.
    localparam int unsigned BURST_LEN  = 2;
    localparam int unsigned BEAT_EVEN  = 0;
    localparam int unsigned BEAT_ODD   = 1;
    localparam int unsigned DEF_PAIR_AW = 7;
    localparam int unsigned DEF_DATA_W  = 36;
    localparam int unsigned DEF_LANE_W  = 9;
endpackage

// File: rtl/qdrb2_wr_buf.sv
module qdrb2_wr_buf #(
    parameter int unsigned DATA_W = qdrb2_pkg::DEF_DATA_W,
    parameter int unsigned LANE_W = qdrb2_pkg::DEF_LANE_W,
    localparam int unsigned LANES = DATA_W / LANE_W
) (
    input  logic              k_clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] d,
    input  logic [LANES-1:0]  bw_n,
    output logic              wb_valid,
    output logic [DATA_W-1:0] wb_data,
    output logic [LANES-1:0]  wb_mask
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  mask;
    } wb_t;

    wb_t wb_d, wb_q;

    always_comb begin
        wb_d       = wb_q;
        wb_d.valid = !wr_n && !rst;
        wb_d.data  = d;
        wb_d.mask  = bw_n;
    end

    always_ff @(posedge k_clk) begin
        wb_q <= wb_d;
    end

    assign wb_valid = wb_q.valid;
    assign wb_data  = wb_q.data;
    assign wb_mask  = wb_q.mask;

    // R3: beat-0 data and masks must be defined at the capturing K edge
    a_r3_beat0_known: assert property (@(posedge k_clk) disable iff (rst)
        !wr_n |-> !$isunknown({d, bw_n}));
endmodule

// File: rtl/qdrb2_array.sv
module qdrb2_array #(
    parameter int unsigned PAIR_AW = qdrb2_pkg::DEF_PAIR_AW,
    parameter int unsigned DATA_W  = qdrb2_pkg::DEF_DATA_W,
    parameter int unsigned LANE_W  = qdrb2_pkg::DEF_LANE_W,
    localparam int unsigned LANES  = DATA_W / LANE_W,
    localparam int unsigned PAIRS  = 1 << PAIR_AW
) (
    input  logic               kn_clk,
    input  logic               rst,
    input  logic               wb_valid,
    input  logic [DATA_W-1:0]  wb_data,
    input  logic [LANES-1:0]   wb_mask,
    input  logic [PAIR_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0]  d,
    input  logic [LANES-1:0]   bw_n,
    input  logic [PAIR_AW-1:0] rd_addr,
    output logic [DATA_W-1:0]  rd_even,
    output logic [DATA_W-1:0]  rd_odd
);
    import qdrb2_pkg::*;

    typedef struct packed {
        logic               commit;
        logic [PAIR_AW-1:0] addr;
        logic [DATA_W-1:0]  even;
        logic [DATA_W-1:0]  odd;
    } wr_t;

    logic [DATA_W-1:0] mem_q [PAIRS][BURST_LEN];

    logic [DATA_W-1:0] beat_data [BURST_LEN];
    logic [LANES-1:0]  beat_mask [BURST_LEN];
    logic [DATA_W-1:0] old_word  [BURST_LEN];
    logic [DATA_W-1:0] new_word  [BURST_LEN];
    wr_t               wr_d;

    // Beat 0 comes from the early buffer, beat 1 straight from the pins.
    assign beat_data[BEAT_EVEN] = wb_data;
    assign beat_mask[BEAT_EVEN] = wb_mask;
    assign beat_data[BEAT_ODD]  = d;
    assign beat_mask[BEAT_ODD]  = bw_n;

    for (genvar b = 0; b < BURST_LEN; b++) begin : g_beat
        assign old_word[b] = mem_q[wr_addr][b];
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign new_word[b][l*LANE_W +: LANE_W] = beat_mask[b][l]
                ? old_word[b][l*LANE_W +: LANE_W]
                : beat_data[b][l*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        wr_d.commit = wb_valid && !rst;
        wr_d.addr   = wr_addr;
        wr_d.even   = new_word[BEAT_EVEN];
        wr_d.odd    = new_word[BEAT_ODD];
    end

    always_ff @(posedge kn_clk) begin
        if (wr_d.commit) begin
            mem_q[wr_d.addr][BEAT_EVEN] <= wr_d.even;
            mem_q[wr_d.addr][BEAT_ODD]  <= wr_d.odd;
        end
    end

    assign rd_even = mem_q[rd_addr][BEAT_EVEN];
    assign rd_odd  = mem_q[rd_addr][BEAT_ODD];

    // R3: address, beat-1 data and masks must be defined when a write commits
    a_r3_commit_known: assert property (@(posedge kn_clk) disable iff (rst)
        wb_valid |-> !$isunknown({wr_addr, d, bw_n}));
endmodule

// File: rtl/qdrb2_rd_pipe.sv
module qdrb2_rd_pipe #(
    parameter int unsigned PAIR_AW = qdrb2_pkg::DEF_PAIR_AW,
    parameter int unsigned DATA_W  = qdrb2_pkg::DEF_DATA_W
) (
    input  logic               k_clk,
    input  logic               kn_clk,
    input  logic               rst,
    input  logic               rd_n,
    input  logic [PAIR_AW-1:0] rd_addr,
    output logic [PAIR_AW-1:0] arr_addr,
    input  logic [DATA_W-1:0]  arr_even,
    input  logic [DATA_W-1:0]  arr_odd,
    output logic [DATA_W-1:0]  q,
    output logic               q_valid
);
    // K-domain: request stage, snapshot stage, odd-beat output register
    typedef struct packed {
        logic               s1_vld;
        logic [PAIR_AW-1:0] s1_addr;
        logic               s2_vld;
        logic [DATA_W-1:0]  s2_even;
        logic [DATA_W-1:0]  s2_odd;
        logic               vk;
        logic [DATA_W-1:0]  qk;
    } kst_t;

    // K_n-domain: even-beat output register
    typedef struct packed {
        logic              vkn;
        logic [DATA_W-1:0] qkn;
    } nst_t;

    kst_t k_d, k_q;
    nst_t n_d, n_q;

    always_comb begin
        k_d         = k_q;
        k_d.s1_vld  = !rd_n;
        k_d.s1_addr = rd_addr;
        k_d.s2_vld  = k_q.s1_vld;
        k_d.s2_even = arr_even;
        k_d.s2_odd  = arr_odd;
        k_d.vk      = k_q.s2_vld;
        k_d.qk      = k_q.s2_vld ? k_q.s2_odd : '0;
        if (rst) begin
            k_d.s1_vld = 1'b0;
            k_d.s2_vld = 1'b0;
            k_d.vk     = 1'b0;
            k_d.qk     = '0;
        end
    end

    always_ff @(posedge k_clk) begin
        k_q <= k_d;
    end

    always_comb begin
        n_d.vkn = k_q.s2_vld && !rst;
        n_d.qkn = (k_q.s2_vld && !rst) ? k_q.s2_even : '0;
    end

    always_ff @(posedge kn_clk) begin
        n_q <= n_d;
    end

    assign arr_addr = k_q.s1_addr;

    // High K phase shows the odd-beat register, low phase the even-beat one.
    assign q       = k_clk ? k_q.qk : n_q.qkn;
    assign q_valid = k_clk ? k_q.vk : n_q.vkn;

    // R2: a requested read must carry a defined address
    a_r2_addr_known: assert property (@(posedge k_clk) disable iff (rst)
        !rd_n |-> !$isunknown(rd_addr));

    // R5: the odd beat of an accepted read is presented two cycles later
    a_r5_latency: assert property (@(posedge k_clk) disable iff (rst)
        !rd_n |=> ##2 k_q.vk);

    // R6: no read accepted means no odd beat two cycles later
    a_r6_no_spurious: assert property (@(posedge k_clk) disable iff (rst)
        rd_n |=> ##2 !k_q.vk);

    // R1: an even beat is always followed by its odd beat
    a_r1_pair_follows: assert property (@(posedge k_clk) disable iff (rst)
        n_q.vkn |=> k_q.vk);

    // R9: consecutive reads keep both half-cycle registers valid
    a_r9_back_to_back: assert property (@(posedge k_clk) disable iff (rst)
        (!rd_n ##1 !rd_n) |=> ##1 (k_q.vk && n_q.vkn));
endmodule

// File: rtl/qdrb2_sram.sv
module qdrb2_sram #(
    parameter int unsigned PAIR_AW = qdrb2_pkg::DEF_PAIR_AW,
    parameter int unsigned DATA_W  = qdrb2_pkg::DEF_DATA_W,
    parameter int unsigned LANE_W  = qdrb2_pkg::DEF_LANE_W,
    localparam int unsigned LANES  = DATA_W / LANE_W
) (
    input  logic               k_clk,
    input  logic               kn_clk,
    input  logic               rst,
    input  logic               rd_n,
    input  logic [PAIR_AW-1:0] rd_addr,
    input  logic               wr_n,
    input  logic [PAIR_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0]  d,
    input  logic [LANES-1:0]   bw_n,
    output logic [DATA_W-1:0]  q,
    output logic               q_valid
);
    logic               wb_valid;
    logic [DATA_W-1:0]  wb_data;
    logic [LANES-1:0]   wb_mask;
    logic [PAIR_AW-1:0] arr_addr;
    logic [DATA_W-1:0]  arr_even;
    logic [DATA_W-1:0]  arr_odd;

    qdrb2_wr_buf #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_wr_buf (
        .k_clk    (k_clk),
        .rst      (rst),
        .wr_n     (wr_n),
        .d        (d),
        .bw_n     (bw_n),
        .wb_valid (wb_valid),
        .wb_data  (wb_data),
        .wb_mask  (wb_mask)
    );

    qdrb2_array #(.PAIR_AW(PAIR_AW), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
        .kn_clk   (kn_clk),
        .rst      (rst),
        .wb_valid (wb_valid),
        .wb_data  (wb_data),
        .wb_mask  (wb_mask),
        .wr_addr  (wr_addr),
        .d        (d),
        .bw_n     (bw_n),
        .rd_addr  (arr_addr),
        .rd_even  (arr_even),
        .rd_odd   (arr_odd)
    );

    qdrb2_rd_pipe #(.PAIR_AW(PAIR_AW), .DATA_W(DATA_W)) u_rd_pipe (
        .k_clk    (k_clk),
        .kn_clk   (kn_clk),
        .rst      (rst),
        .rd_n     (rd_n),
        .rd_addr  (rd_addr),
        .arr_addr (arr_addr),
        .arr_even (arr_even),
        .arr_odd  (arr_odd),
        .q        (q),
        .q_valid  (q_valid)
    );
endmodule

// File: tb/qdrb2_sram_tb.sv
`timescale 1ns/1ps
module qdrb2_sram_tb;
    logic        k_clk = 1'b0;
    logic        kn_clk;
    logic        rst = 1'b1;
    logic        rd_n = 1'b1;
    logic [6:0]  rd_addr = '0;
    logic        wr_n = 1'b1;
    logic [6:0]  wr_addr = '0;
    logic [35:0] d = '0;
    logic [3:0]  bw_n = 4'hF;
    logic [35:0] q;
    logic        q_valid;

    int checks = 0;
    int fails  = 0;
    logic [35:0] mdl [256];

    always #5 k_clk = ~k_clk;
    assign kn_clk = ~k_clk;

    qdrb2_sram u_dut (
        .k_clk(k_clk), .kn_clk(kn_clk), .rst(rst),
        .rd_n(rd_n), .rd_addr(rd_addr), .wr_n(wr_n), .wr_addr(wr_addr),
        .d(d), .bw_n(bw_n), .q(q), .q_valid(q_valid)
    );

    typedef struct packed {
        logic        rd;
        logic [6:0]  ra;
        logic        wr;
        logic [6:0]  wa;
        logic [35:0] d0;
        logic [3:0]  m0;
        logic [35:0] d1;
        logic [3:0]  m1;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b0, 7'd0,   1'b1, 7'd1,   36'h111111111, 4'h0, 36'h222222222, 4'h0},
        '{1'b0, 7'd0,   1'b1, 7'd2,   36'hAAAAAAAAA, 4'h0, 36'h555555555, 4'h0},
        '{1'b1, 7'd1,   1'b0, 7'd0,   36'h0,         4'hF, 36'h0,         4'hF},
        '{1'b1, 7'd2,   1'b1, 7'd3,   36'h0F0F0F0F0, 4'h0, 36'h123456789, 4'h0},
        '{1'b1, 7'd3,   1'b0, 7'd0,   36'h0,         4'hF, 36'h0,         4'hF},
        '{1'b1, 7'd1,   1'b1, 7'd1,   36'hFFFFFFFFF, 4'h5, 36'h000000000, 4'hA},
        '{1'b1, 7'd2,   1'b1, 7'd2,   36'h000000000, 4'hF, 36'hFEDCBA987, 4'hE},
        '{1'b1, 7'd1,   1'b0, 7'd0,   36'h0,         4'hF, 36'h0,         4'hF},
        '{1'b0, 7'd0,   1'b1, 7'd0,   36'h0DEADBEEF, 4'h0, 36'h0CAFEF00D, 4'h0},
        '{1'b1, 7'd0,   1'b0, 7'd0,   36'h0,         4'hF, 36'h0,         4'hF},
        '{1'b1, 7'd127, 1'b1, 7'd127, 36'hFFFFFFFFF, 4'h0, 36'h800000001, 4'h0},
        '{1'b1, 7'd3,   1'b0, 7'd0,   36'h0,         4'hF, 36'h0,         4'hF}
    };

    function automatic string tag_of(int v);
        case (v)
            0, 1, 8: return "R3";
            2:       return "R2";
            3, 4:    return "R8";
            5, 10:   return "R7";
            6, 7:    return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [35:0] merge(logic [35:0] old_w, logic [35:0] new_w, logic [3:0] m);
        logic [35:0] r = old_w;
        for (int l = 0; l < 4; l++)
            if (!m[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        return r;
    endfunction

    task automatic model_write(logic [6:0] wa, logic [35:0] d0, logic [3:0] m0,
                               logic [35:0] d1, logic [3:0] m1);
        mdl[{wa, 1'b0}] = merge(mdl[{wa, 1'b0}], d0, m0);
        mdl[{wa, 1'b1}] = merge(mdl[{wa, 1'b1}], d1, m1);
    endtask

    task automatic chk(string tag, logic exp_v, logic [35:0] exp_q);
        logic [35:0] e = exp_v ? exp_q : 36'h0;
        checks++;
        if (q_valid !== exp_v || q !== e) begin
            fails++;
            $display("FAIL %s: valid/q = %0b/%h expected %0b/%h", tag, q_valid, q, exp_v, e);
        end
    endtask

    // Drives one K cycle: command-side inputs before K, K_n-side after it.
    task automatic cycle(logic rs, logic rd, logic [6:0] ra, logic wr, logic [6:0] wa,
                         logic [35:0] d0, logic [3:0] m0, logic [35:0] d1, logic [3:0] m1);
        @(posedge kn_clk);
        #2;
        rst = rs; rd_n = !rd; rd_addr = ra; wr_n = !wr; d = d0; bw_n = m0;
        @(posedge k_clk);
        #2;
        rd_n = 1'b1; wr_n = 1'b1; rd_addr = ra ^ 7'h55;
        wr_addr = wa; d = d1; bw_n = m1;
    endtask

    task automatic idle(logic rs);
        cycle(rs, 1'b0, 7'd0, 1'b0, 7'd0, 36'h0, 4'hF, 36'h0, 4'hF);
    endtask

    // One access followed by a check of both beats and the idle half after.
    task automatic op(logic rd, logic [6:0] ra, logic wr, logic [6:0] wa,
                      logic [35:0] d0, logic [3:0] m0, logic [35:0] d1, logic [3:0] m1,
                      string tag);
        logic [35:0] e0, e1;
        cycle(1'b0, rd, ra, wr, wa, d0, m0, d1, m1);
        if (wr) model_write(wa, d0, m0, d1, m1);
        e0 = mdl[{ra, 1'b0}];
        e1 = mdl[{ra, 1'b1}];
        idle(1'b0);
        #5 chk(tag,  rd, e0);
        #5 chk("R1", rd, e1);
        #5 chk("R6", 1'b0, 36'h0);
    endtask

    initial begin
        repeat (200000) @(posedge k_clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [35:0] e0, e1, e2, e3;
        repeat (4) @(posedge k_clk);
        idle(1'b1);
        idle(1'b0);
        idle(1'b0);
        // R10: reset state in both clock phases
        #3 chk("R10", 1'b0, 36'h0);
        #5 chk("R10", 1'b0, 36'h0);

        for (int v = 0; v < 12; v++)
            op(VECS[v].rd, VECS[v].ra, VECS[v].wr, VECS[v].wa,
               VECS[v].d0, VECS[v].m0, VECS[v].d1, VECS[v].m1, tag_of(v));

        // R4: single-lane writes on each beat
        op(1'b0, 7'd0, 1'b1, 7'd6, 36'h0, 4'h0, 36'h0, 4'h0, "R4");
        op(1'b1, 7'd6, 1'b1, 7'd6, 36'hFFFFFFFFF, 4'hE, 36'hFFFFFFFFF, 4'h7, "R4");
        checks++;
        if (mdl[12] !== 36'h0000001FF || mdl[13] !== 36'hFF8000000) begin
            fails++;
            $display("FAIL R4: model %h/%h expected 0000001ff/ff8000000", mdl[12], mdl[13]);
        end

        // R9: reads on consecutive K edges
        e0 = mdl[2]; e1 = mdl[3]; e2 = mdl[4]; e3 = mdl[5];
        cycle(1'b0, 1'b1, 7'd1, 1'b0, 7'd0, 36'h0, 4'hF, 36'h0, 4'hF);
        cycle(1'b0, 1'b1, 7'd2, 1'b0, 7'd0, 36'h0, 4'hF, 36'h0, 4'hF);
        #5 chk("R9", 1'b1, e0);
        #5 chk("R9", 1'b1, e1);
        #5 chk("R9", 1'b1, e2);
        #5 chk("R9", 1'b1, e3);
        #5 chk("R9", 1'b0, 36'h0);

        // R7: write then read on the next edge sees the new data
        cycle(1'b0, 1'b0, 7'd0, 1'b1, 7'd5, 36'h0A0A0A0A0, 4'h0, 36'h0B0B0B0B0, 4'h0);
        model_write(7'd5, 36'h0A0A0A0A0, 4'h0, 36'h0B0B0B0B0, 4'h0);
        op(1'b1, 7'd5, 1'b0, 7'd0, 36'h0, 4'hF, 36'h0, 4'hF, "R7");
        // R7: a write one edge after the read does not affect it
        e0 = mdl[10]; e1 = mdl[11];
        cycle(1'b0, 1'b1, 7'd5, 1'b0, 7'd0, 36'h0, 4'hF, 36'h0, 4'hF);
        cycle(1'b0, 1'b0, 7'd0, 1'b1, 7'd5, 36'h0C0C0C0C0, 4'h0, 36'h0D0D0D0D0, 4'h0);
        model_write(7'd5, 36'h0C0C0C0C0, 4'h0, 36'h0D0D0D0D0, 4'h0);
        #5 chk("R7", 1'b1, e0);
        #5 chk("R7", 1'b1, e1);
        #5 chk("R6", 1'b0, 36'h0);
        op(1'b1, 7'd5, 1'b0, 7'd0, 36'h0, 4'hF, 36'h0, 4'hF, "R7");

        // R10: reset while a read is in flight suppresses its beats
        cycle(1'b0, 1'b1, 7'd1, 1'b0, 7'd0, 36'h0, 4'hF, 36'h0, 4'hF);
        idle(1'b1);
        #5 chk("R10", 1'b0, 36'h0);
        #5 chk("R10", 1'b0, 36'h0);
        idle(1'b0);
        // R10: write under reset is dropped, array contents kept
        cycle(1'b1, 1'b0, 7'd0, 1'b1, 7'd1, 36'h0, 4'h0, 36'h0, 4'h0);
        idle(1'b0);
        op(1'b1, 7'd1, 1'b0, 7'd0, 36'h0, 4'hF, 36'h0, 4'hF, "R10");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule